// File: doc/BRIEF.md
# Multi-Task Heartbeat Rate Monitor

This block decides, once per fixed evaluation period, whether a watchdog may be restarted. Each software task that must stay alive drives its own heartbeat line high for one clock per loop iteration. The monitor counts these pulses per channel. When the period ends it checks that every count sits strictly inside that channel's own window and that a system-health input is high. A single restart pulse goes to the external watchdog only if all of these hold.

A task that stalls fails its lower bound. A task that spins too fast fails its upper bound. In either case the restart is withheld, so the watchdog eventually fires. Failing channels are recorded in a sticky bitmap that software can read after recovery and clear. The counters restart from zero after every evaluation, whether it passed or failed. Window bounds sit in writable registers that take built-in defaults at reset. The defaults suit three tasks running roughly 20, 10 and 8 times per period.

Top module: `hb_rate_monitor`

## Requirements
- R1: Each clock cycle in which `hb_pulse[c]` is high adds exactly one to channel c's count for the current period.
- R2: An evaluation happens every `PERIOD_CYC` clock cycles. Its outcome appears on `wd_restart` or `err_pulse` on the `PERIOD_CYC`-th rising edge after reset is released, and then every `PERIOD_CYC` edges. Neither output is high in any other cycle.
- R3: Channel c passes only when its count is strictly greater than its lower bound and strictly less than its upper bound. A count equal to either bound fails.
- R4: `wd_restart` is a one-cycle pulse. It is raised only when every channel passes and `health_ok` is high in the evaluation cycle.
- R5: If `health_ok` is low in the evaluation cycle, the block gives no restart, pulses `err_pulse`, and sets the sticky `health_fault`. Any failing evaluation pulses `err_pulse` for one cycle.
- R6: Bit c of `fail_map` is set when channel c fails an evaluation. Set bits stay set until `fail_clr` is high. If a clear falls in the same cycle as an evaluation, the new failures of that evaluation are kept.
- R7: Every evaluation, passing or failing, returns all counts to zero.
- R8: Counts saturate at 2^`CNT_W`-1 and never wrap.
- R9: A heartbeat in the evaluation cycle is not part of the ending period. The new period starts with a count of one for that channel.
- R10: After reset the bounds (low, high) are (18,22) for channel 0, (8,12) for channel 1 and (6,10) for channel 2. A cycle with `cfg_wr_en` high loads `cfg_lo_val`/`cfg_hi_val` into channel `cfg_wr_sel`, and later evaluations use the new values.
- R11: During reset `wd_restart`, `err_pulse`, `fail_map` and `health_fault` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_pulse | input | NUM_CH | One heartbeat per high cycle, one bit per task |
| health_ok | input | 1 | External system-health condition, sampled at evaluation |
| cfg_wr_en | input | 1 | Bound register write strobe |
| cfg_wr_sel | input | SEL_W | Channel selected for the write |
| cfg_lo_val | input | CNT_W | New lower bound (exclusive) |
| cfg_hi_val | input | CNT_W | New upper bound (exclusive) |
| fail_clr | input | 1 | Clears `fail_map` and `health_fault` |
| wd_restart | output | 1 | One-cycle restart pulse to the watchdog |
| err_pulse | output | 1 | One-cycle pulse on a failing evaluation |
| fail_map | output | NUM_CH | Sticky per-channel failure bits |
| health_fault | output | 1 | Sticky: an evaluation saw `health_ok` low |

## Verification
Two situations are hard to reach from the ports: a heartbeat that lands exactly on the evaluation edge, and a count pushed past saturation. Both depend on exact cycle alignment or on long pulse trains. The bench keeps its own cycle count of each period from reset. It can therefore place a heartbeat on the last cycle, or a fail clear on the evaluation edge. It then observes the effect one period later through the pass/fail outcome. For saturation, the bench narrows a channel's window so that a wrapped count would pass and a saturated count fails, then drives more pulses than the counter can hold.

// File: rtl/hbm_pkg.sv
// Package: shared types for the heartbeat rate monitor.
package hbm_pkg;

    // Outcome of the most recent evaluation, held for one cycle.
    typedef enum logic [1:0] {
        VERD_IDLE = 2'd0,
        VERD_PASS = 2'd1,
        VERD_FAIL = 2'd2
    } verdict_t;

endpackage

// File: rtl/hbm_period_timer.sv
// Module: hbm_period_timer
// Free-running cycle counter that raises eval_tick once every PERIOD_CYC
// cycles, on the last cycle of each period.
// Assumes PERIOD_CYC >= 2.
module hbm_period_timer #(
    parameter int PERIOD_CYC = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic eval_tick
);
    localparam int TMR_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(PERIOD_CYC - 1);

    logic [TMR_W-1:0] tmr_q;

    assign eval_tick = (tmr_q == LAST);

    // Advance the period counter; wrap to zero on the evaluation cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (eval_tick) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end
endmodule

// File: rtl/hbm_chan_counter.sv
// Module: hbm_chan_counter
// Saturating heartbeat counter for one channel. On eval_tick the count
// restarts, and a heartbeat in that same cycle becomes the first event of
// the new period.
// Assumes hb is synchronous to clk and high for one cycle per event.
module hbm_chan_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hb,
    input  logic             eval_tick,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_max;

    assign at_max = (cnt_q == {CNT_W{1'b1}});
    assign count  = cnt_q;

    // Count heartbeats, hold at the maximum, restart at each evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (eval_tick) begin
            cnt_q <= CNT_W'(hb);
        end else if (hb && !at_max) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hbm_bound_regs.sv
// Module: hbm_bound_regs
// Per-channel exclusive window bounds. The registers load their defaults
// in reset, and a write strobe overwrites one channel at a time.
// Assumes writes to a channel index >= NUM_CH are dropped.
module hbm_bound_regs #(
    parameter int                      NUM_CH  = 3,
    parameter int                      CNT_W   = 8,
    parameter int                      SEL_W   = 2,
    parameter logic [NUM_CH*CNT_W-1:0] LO_INIT = '0,
    parameter logic [NUM_CH*CNT_W-1:0] HI_INIT = '1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [CNT_W-1:0]        wr_lo,
    input  logic [CNT_W-1:0]        wr_hi,
    output logic [NUM_CH*CNT_W-1:0] lo_flat,
    output logic [NUM_CH*CNT_W-1:0] hi_flat
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_bound
        logic [CNT_W-1:0] lo_q;
        logic [CNT_W-1:0] hi_q;
        logic             hit;

        assign hit = wr_en && (wr_sel == SEL_W'(g));

        // Hold this channel's bounds; load the defaults or a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= LO_INIT[g*CNT_W +: CNT_W];
                hi_q <= HI_INIT[g*CNT_W +: CNT_W];
            end else if (hit) begin
                lo_q <= wr_lo;
                hi_q <= wr_hi;
            end
        end

        assign lo_flat[g*CNT_W +: CNT_W] = lo_q;
        assign hi_flat[g*CNT_W +: CNT_W] = hi_q;
    end
endmodule

// File: rtl/hbm_window_cmp.sv
// Module: hbm_window_cmp
// Pure combinational test that a count lies strictly between two bounds.
// Assumes unsigned operands. An empty window (hi <= lo+1) never passes.
module hbm_window_cmp #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] lo,
    input  logic [CNT_W-1:0] hi,
    output logic             in_win
);
    // Exclusive window: equality with either bound is a failure.
    always_comb begin
        in_win = (count > lo) && (count < hi);
    end
endmodule

// File: rtl/hb_rate_monitor.sv
// Module: hb_rate_monitor (top)
// Counts heartbeats per task over a fixed period. At the period end it
// compares every count with its exclusive window and gates the watchdog
// restart with health_ok. It records failures in sticky flags.
// Assumes all inputs are synchronous to clk and PERIOD_CYC >= 2.
module hb_rate_monitor #(
    parameter int                      NUM_CH      = 3,
    parameter int                      CNT_W       = 8,
    parameter int                      PERIOD_CYC  = 200_000_000,
    parameter logic [NUM_CH*CNT_W-1:0] LO_DEFAULTS = {CNT_W'(6), CNT_W'(8), CNT_W'(18)},
    parameter logic [NUM_CH*CNT_W-1:0] HI_DEFAULTS = {CNT_W'(10), CNT_W'(12), CNT_W'(22)},
    localparam int                     SEL_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hb_pulse,
    input  logic              health_ok,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_wr_sel,
    input  logic [CNT_W-1:0]  cfg_lo_val,
    input  logic [CNT_W-1:0]  cfg_hi_val,
    input  logic              fail_clr,
    output logic              wd_restart,
    output logic              err_pulse,
    output logic [NUM_CH-1:0] fail_map,
    output logic              health_fault
);
    import hbm_pkg::*;

    logic                    eval_tick;
    logic [NUM_CH*CNT_W-1:0] lo_flat;
    logic [NUM_CH*CNT_W-1:0] hi_flat;
    logic [NUM_CH-1:0]       in_win;
    logic                    pass_now;
    verdict_t                verdict_q;
    logic [NUM_CH-1:0]       fail_map_q;
    logic                    health_fault_q;

    hbm_period_timer #(
        .PERIOD_CYC (PERIOD_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_tick (eval_tick)
    );

    hbm_bound_regs #(
        .NUM_CH  (NUM_CH),
        .CNT_W   (CNT_W),
        .SEL_W   (SEL_W),
        .LO_INIT (LO_DEFAULTS),
        .HI_INIT (HI_DEFAULTS)
    ) u_bounds (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_lo   (cfg_lo_val),
        .wr_hi   (cfg_hi_val),
        .lo_flat (lo_flat),
        .hi_flat (hi_flat)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic [CNT_W-1:0] count;

        hbm_chan_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .hb        (hb_pulse[c]),
            .eval_tick (eval_tick),
            .count     (count)
        );

        hbm_window_cmp #(
            .CNT_W (CNT_W)
        ) u_cmp (
            .count  (count),
            .lo     (lo_flat[c*CNT_W +: CNT_W]),
            .hi     (hi_flat[c*CNT_W +: CNT_W]),
            .in_win (in_win[c])
        );
    end

    assign pass_now = (&in_win) && health_ok;

    // Register the outcome of an evaluation as a one-cycle verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= VERD_IDLE;
        end else if (eval_tick) begin
            verdict_q <= pass_now ? VERD_PASS : VERD_FAIL;
        end else begin
            verdict_q <= VERD_IDLE;
        end
    end

    // Accumulate sticky failure flags; new failures win over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_map_q     <= '0;
            health_fault_q <= 1'b0;
        end else begin
            fail_map_q     <= (fail_clr ? '0 : fail_map_q)
                            | (eval_tick ? ~in_win : '0);
            health_fault_q <= (fail_clr ? 1'b0 : health_fault_q)
                            | (eval_tick && !health_ok);
        end
    end

    assign wd_restart   = (verdict_q == VERD_PASS);
    assign err_pulse    = (verdict_q == VERD_FAIL);
    assign fail_map     = fail_map_q;
    assign health_fault = health_fault_q;
endmodule

// File: rtl/hbm_checker.sv
// Module: hbm_checker
// Protocol properties of hb_rate_monitor, seen from its ports. It keeps its
// own period count so that the outcome timing is checked independently.
module hbm_checker #(
    parameter int NUM_CH     = 3,
    parameter int PERIOD_CYC = 200_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              health_ok,
    input logic              fail_clr,
    input logic              wd_restart,
    input logic              err_pulse,
    input logic [NUM_CH-1:0] fail_map,
    input logic              health_fault
);
    localparam int CK_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CK_W-1:0] CK_LAST = CK_W'(PERIOD_CYC - 1);

    logic [CK_W-1:0] ck_q;
    logic            due_q;

    // Shadow period counter and a flag for the cycle after its wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_q  <= '0;
            due_q <= 1'b0;
        end else begin
            ck_q  <= (ck_q == CK_LAST) ? '0 : ck_q + 1'b1;
            due_q <= (ck_q == CK_LAST);
        end
    end

    // R2: an outcome appears exactly once per period, in the expected cycle.
    p_outcome_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_restart || err_pulse) == due_q);

    // R4: a restart and an error never appear together.
    p_excl_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wd_restart && err_pulse));

    // R4: the restart is a single-cycle pulse.
    p_restart_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wd_restart |=> !wd_restart);

    // R5: a restart implies health was good at the evaluation edge.
    p_health_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wd_restart |-> $past(health_ok));

    // R5: a failing outcome always leaves a recorded cause.
    p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ((fail_map != '0) || health_fault));

    // R6: without a clear, no failure bit is ever dropped.
    p_sticky_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fail_clr) |-> ((fail_map & $past(fail_map)) == $past(fail_map)));

    // R6: failure bits only grow in an outcome cycle.
    p_map_grows_on_eval_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!due_q && !$past(fail_clr)) |-> $stable(fail_map));
endmodule

bind hb_rate_monitor hbm_checker #(
    .NUM_CH     (NUM_CH),
    .PERIOD_CYC (PERIOD_CYC)
) u_hbm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .health_ok    (health_ok),
    .fail_clr     (fail_clr),
    .wd_restart   (wd_restart),
    .err_pulse    (err_pulse),
    .fail_map     (fail_map),
    .health_fault (health_fault)
);

// File: tb/hb_rate_monitor_test.sv
// Bench for hb_rate_monitor: directed corner cases plus seeded random
// periods, checked against a model of counts and bounds kept in the bench.
module hb_rate_monitor_test;
    localparam int P  = 300;
    localparam int NC = 3;
    localparam int CW = 8;
    localparam int MAXC = 255;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] hb_pulse = '0;
    logic          health_ok = 1'b1;
    logic          cfg_wr_en = 1'b0;
    logic [1:0]    cfg_wr_sel = '0;
    logic [CW-1:0] cfg_lo_val = '0;
    logic [CW-1:0] cfg_hi_val = '0;
    logic          fail_clr = 1'b0;
    logic          wd_restart;
    logic          err_pulse;
    logic [NC-1:0] fail_map;
    logic          health_fault;

    int checks = 0;
    int fails  = 0;

    // Bench-side model state.
    int          m_lo [NC] = '{18, 8, 6};
    int          m_hi [NC] = '{22, 12, 10};
    int          m_carry [NC] = '{0, 0, 0};
    logic [NC-1:0] m_map = '0;
    logic        m_hf = 1'b0;

    // Pending actions applied inside the next period.
    logic        pend_wr = 1'b0;
    int          pend_ch = 0, pend_lo = 0, pend_hi = 0;
    int          clr_mode = 0; // 0 none, 1 at period start, 2 at evaluation edge

    always #2.5 clk = ~clk;

    hb_rate_monitor #(
        .NUM_CH     (NC),
        .CNT_W      (CW),
        .PERIOD_CYC (P)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hb_pulse     (hb_pulse),
        .health_ok    (health_ok),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_sel   (cfg_wr_sel),
        .cfg_lo_val   (cfg_lo_val),
        .cfg_hi_val   (cfg_hi_val),
        .fail_clr     (fail_clr),
        .wd_restart   (wd_restart),
        .err_pulse    (err_pulse),
        .fail_map     (fail_map),
        .health_fault (health_fault)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    function automatic bit in_window(input int cnt, input int lo, input int hi);
        return (cnt > lo) && (cnt < hi);
    endfunction

    // Run one full period from its first cycle. Channel c gets n[c] heartbeats
    // in consecutive cycles. late0 adds a channel-0 beat in the evaluation cycle.
    task automatic run_period(input int n0, input int n1, input int n2,
                              input bit hok, input bit late0, input string tag);
        int            n [NC];
        int            cnt [NC];
        logic [NC-1:0] bad;
        bit            allp;
        n[0] = n0; n[1] = n1; n[2] = n2;
        for (int i = 0; i < P; i++) begin
            for (int c = 0; c < NC; c++)
                hb_pulse[c] = (i < n[c]) || (c == 0 && late0 && i == P - 1);
            health_ok  = hok;
            cfg_wr_en  = pend_wr && (i == 0);
            cfg_wr_sel = 2'(pend_ch);
            cfg_lo_val = CW'(pend_lo);
            cfg_hi_val = CW'(pend_hi);
            fail_clr   = (clr_mode == 1 && i == 0) || (clr_mode == 2 && i == P - 1);
            if (i == P - 1)
                check({"R2 no early outcome ", tag}, int'(wd_restart | err_pulse), 0);
            @(posedge clk);
            @(negedge clk);
        end
        hb_pulse = '0; cfg_wr_en = 1'b0; fail_clr = 1'b0; health_ok = 1'b1;
        // Model the evaluation.
        if (pend_wr) begin
            m_lo[pend_ch] = pend_lo;
            m_hi[pend_ch] = pend_hi;
        end
        if (clr_mode != 0) begin
            m_map = '0;
            m_hf  = 1'b0;
        end
        for (int c = 0; c < NC; c++) begin
            cnt[c] = sat(n[c] + m_carry[c]);
            bad[c] = !in_window(cnt[c], m_lo[c], m_hi[c]);
        end
        allp  = (bad == '0) && hok;
        m_map = m_map | bad;
        m_hf  = m_hf | !hok;
        check({"R4 restart ", tag}, int'(wd_restart), int'(allp));
        check({"R5 err_pulse ", tag}, int'(err_pulse), int'(!allp));
        check({"R6 fail_map ", tag}, int'(fail_map), int'(m_map));
        check({"R5 health_fault ", tag}, int'(health_fault), int'(m_hf));
        for (int c = 0; c < NC; c++) m_carry[c] = 0;
        if (late0) m_carry[0] = 1;
        pend_wr  = 1'b0;
        clr_mode = 0;
    endtask

    task automatic queue_write(input int ch, input int lo, input int hi);
        pend_wr = 1'b1; pend_ch = ch; pend_lo = lo; pend_hi = hi;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11: reset state.
        check("R11 restart in reset", int'(wd_restart), 0);
        check("R11 err in reset", int'(err_pulse), 0);
        check("R11 fail_map in reset", int'(fail_map), 0);
        check("R11 health_fault in reset", int'(health_fault), 0);
        rst_n = 1'b1;

        // R1 R4 R10: nominal rates inside the default windows.
        run_period(20, 10, 8, 1'b1, 1'b0, "nominal");
        // R3: one inside each bound passes.
        run_period(19, 9, 7, 1'b1, 1'b0, "lo+1");
        run_period(21, 11, 9, 1'b1, 1'b0, "hi-1");
        // R3: equality with a bound fails, per channel.
        run_period(18, 10, 8, 1'b1, 1'b0, "ch0 at lo");
        run_period(20, 12, 8, 1'b1, 1'b0, "ch1 at hi");
        run_period(20, 10, 6, 1'b1, 1'b0, "ch2 at lo");
        // R6: clear at period start, then a clean pass leaves the map empty.
        clr_mode = 1;
        run_period(20, 10, 8, 1'b1, 1'b0, "clear then pass");
        // R5: health low with good counts.
        run_period(20, 10, 8, 1'b0, 1'b0, "health low");
        clr_mode = 1;
        run_period(20, 10, 8, 1'b1, 1'b0, "health clear");
        // R7: counts restart after a failing period (15 then 5 must fail).
        run_period(15, 10, 8, 1'b1, 1'b0, "r7 short");
        run_period(5, 10, 8, 1'b1, 1'b0, "r7 fresh count");
        // R9: a late beat moves to the next period (21 passes, then 21+1 fails).
        clr_mode = 1;
        run_period(21, 10, 8, 1'b1, 1'b1, "r9 late beat");
        run_period(21, 10, 8, 1'b1, 1'b0, "r9 carried beat");
        // R10: rewrite channel 2's window.
        clr_mode = 1;
        queue_write(2, 2, 5);
        run_period(20, 10, 3, 1'b1, 1'b0, "r10 new window pass");
        run_period(20, 10, 8, 1'b1, 1'b0, "r10 old rate fails");
        // R8: a wrapped count (260 mod 256 = 4) would pass (0,5); saturated fails.
        clr_mode = 1;
        queue_write(1, 0, 5);
        run_period(20, 260, 3, 1'b1, 1'b0, "r8 saturate");
        // R6: a clear on the evaluation edge keeps that evaluation's failures.
        clr_mode = 2;
        run_period(30, 2, 3, 1'b1, 1'b0, "r6 clear at eval");

        // Seeded random periods around the windows.
        for (int k = 0; k < 12; k++) begin
            if (($urandom % 3) == 0) clr_mode = 1 + int'($urandom % 2);
            run_period(int'($urandom % 30), int'($urandom % 8), int'($urandom % 8),
                       ($urandom % 6) != 0, ($urandom % 4) == 0, "random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule